// File: doc/BRIEF.md
# L2 Encapsulation Tag Builder

This block keeps the layer-2 rewrite state of a single forwarding entry while control logic composes its encapsulation one command at a time. A command can restart the entry for an IPv4 or IPv6 flow, push a VLAN ID, attach a switch-port tag or attach a PPPoE session. The block tracks how many tag layers are in use and whether the outer layer is a real VLAN tag. It holds the ethertype word, two VLAN ID slots, a PPPoE flag and a session ID. A VLAN push that finds no free slot is refused, and a one-cycle error pulse is raised. The packet rewrite and the table write are done elsewhere; this block only presents the finished fields on its outputs.

Slot use is governed by a five-state machine. The state encodes both the layer count and the tag flag:
- ST_BARE: no layers.
- ST_ONE_PORT: one layer, taken by a port tag.
- ST_ONE_VLAN: one layer, a VLAN tag.
- ST_TWO_PORT: two layers, outer one re-marked by a port tag.
- ST_TWO_VLAN: two layers, both VLAN tags.

Transitions:
- Init goes to ST_BARE from every state.
- VLAN push: ST_BARE to ST_ONE_VLAN, ST_ONE_VLAN to ST_TWO_VLAN. It stays in ST_ONE_PORT. In both two-layer states it stays and overflows.
- Port tag: ST_BARE, ST_ONE_PORT and ST_ONE_VLAN go to ST_ONE_PORT. ST_TWO_VLAN and ST_TWO_PORT go to ST_TWO_PORT.
- PPPoE never changes the state.

Top module: `l2tag_builder`

## Requirements
- R1: A synchronous reset sets the layer count, tag flag, PPPoE flag, ethertype, both VLAN slots, session ID and error output to zero.
- R2: Init (op 0) takes a flow type code from arg[2:0]. It sets the ethertype to 0x86DD when the code is 4 or higher and to 0x0800 otherwise. It clears the layer count, tag flag, PPPoE flag, both VLAN slots and the session ID.
- R3: Port tag (op 2) with port p = arg[2:0] at layer count 0 sets the ethertype to exactly 1<<p, sets the layer count to 1 and clears the tag flag.
- R4: Port tag at a nonzero layer count sets the ethertype to (1<<p) with bit 8 also set. It leaves the layer count unchanged and clears the tag flag.
- R5: VLAN push (op 1, VID = arg[11:0]) at layer count 0 stores the VID in slot 1, sets the tag flag and sets the layer count to 1.
- R6: VLAN push at layer count 1 with the tag flag clear stores the VID in slot 1 and sets ethertype bit 8. The layer count stays 1 and the tag flag stays clear.
- R7: VLAN push at layer count 1 with the tag flag set stores the VID in slot 2 and raises the layer count to 2.
- R8: VLAN push at layer count 2 raises err_nospace for exactly the following cycle and changes no field.
- R9: PPPoE (op 3) writes 0x8864 into the ethertype only when the layer count is 0 or the tag flag is set. In every case it sets the PPPoE flag and stores arg[15:0] as the session ID.
- R10: While cmd_valid is low, no field changes and err_nospace stays low, whatever cmd_op and cmd_arg carry.
- R11: The layer count never exceeds 2, and err_nospace is never high except after an overflowing VLAN push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 init, 1 VLAN push, 2 port tag, 3 PPPoE |
| cmd_arg | input | 16 | Type code, VID, port number or session ID |
| layer_cnt | output | 3 | Tag layers in use |
| vlan_tagged | output | 1 | Outer layer is a VLAN tag |
| pppoe_on | output | 1 | PPPoE session attached |
| ethertype | output | 16 | Ethertype / port-tag word |
| vlan_id1 | output | 12 | First VLAN slot |
| vlan_id2 | output | 12 | Second VLAN slot |
| session_id | output | 16 | PPPoE session ID |
| err_nospace | output | 1 | One-cycle overflow pulse |

## Verification
A wrong state shows up first in layer_cnt and vlan_tagged, one cycle after the command that caused it. Its lasting damage shows on later commands. A lost tag flag makes the next VLAN push land in slot 1 instead of slot 2, or makes PPPoE skip the 0x8864 rewrite. A wrong two-layer state either lets a third push through or raises err_nospace early. The command sequences therefore chain port tags, VLAN pushes and PPPoE in every state order, so that each state's exit is observed on the cycle right after it is taken.

// File: rtl/l2tag_pkg.sv
package l2tag_pkg;

    typedef enum logic [1:0] {
        OP_INIT  = 2'd0,
        OP_VLAN  = 2'd1,
        OP_PORT  = 2'd2,
        OP_PPPOE = 2'd3
    } l2tag_op_e;

    typedef enum logic [2:0] {
        ST_BARE     = 3'd0,
        ST_ONE_PORT = 3'd1,
        ST_ONE_VLAN = 3'd2,
        ST_TWO_PORT = 3'd3,
        ST_TWO_VLAN = 3'd4
    } l2tag_state_e;

    localparam logic [15:0] ETYPE_IPV4     = 16'h0800;
    localparam logic [15:0] ETYPE_IPV6     = 16'h86DD;
    localparam logic [15:0] ETYPE_PPP_SESS = 16'h8864;
    localparam int unsigned STACK_BIT      = 8;

endpackage

// File: rtl/l2tag_fsm.sv
module l2tag_fsm
    import l2tag_pkg::*;
#(
    parameter int LAYER_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    output logic [LAYER_W-1:0] layer_cnt,
    output logic               vlan_tagged,
    output logic               err_nospace
);

    l2tag_state_e state_q, state_d;
    l2tag_op_e    op;
    logic         overflow_now;
    logic         err_q;

    assign op = l2tag_op_e'(cmd_op);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BARE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= overflow_now;
        end
    end

    // next state
    always_comb begin
        state_d      = state_q;
        overflow_now = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_INIT:  state_d = ST_BARE;
                OP_VLAN: begin
                    unique case (state_q)
                        ST_BARE:     state_d = ST_ONE_VLAN;
                        ST_ONE_PORT: state_d = ST_ONE_PORT;
                        ST_ONE_VLAN: state_d = ST_TWO_VLAN;
                        ST_TWO_PORT,
                        ST_TWO_VLAN: overflow_now = 1'b1;
                        default:     state_d = ST_BARE;
                    endcase
                end
                OP_PORT: begin
                    unique case (state_q)
                        ST_BARE,
                        ST_ONE_PORT,
                        ST_ONE_VLAN: state_d = ST_ONE_PORT;
                        ST_TWO_PORT,
                        ST_TWO_VLAN: state_d = ST_TWO_PORT;
                        default:     state_d = ST_BARE;
                    endcase
                end
                OP_PPPOE: state_d = state_q;
                default:  state_d = state_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_BARE:     begin layer_cnt = LAYER_W'(0); vlan_tagged = 1'b0; end
            ST_ONE_PORT: begin layer_cnt = LAYER_W'(1); vlan_tagged = 1'b0; end
            ST_ONE_VLAN: begin layer_cnt = LAYER_W'(1); vlan_tagged = 1'b1; end
            ST_TWO_PORT: begin layer_cnt = LAYER_W'(2); vlan_tagged = 1'b0; end
            ST_TWO_VLAN: begin layer_cnt = LAYER_W'(2); vlan_tagged = 1'b1; end
            default:     begin layer_cnt = LAYER_W'(0); vlan_tagged = 1'b0; end
        endcase
    end

    assign err_nospace = err_q;

endmodule

// File: rtl/l2tag_fields.sv
module l2tag_fields
    import l2tag_pkg::*;
#(
    parameter int ARG_W    = 16,
    parameter int ETYPE_W  = 16,
    parameter int VID_W    = 12,
    parameter int PORT_W   = 3,
    parameter int SID_W    = 16,
    parameter int TYPE_W   = 3,
    parameter int V6_MIN   = 4,
    parameter int LAYER_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [ARG_W-1:0]   cmd_arg,
    input  logic [LAYER_W-1:0] layer_cnt,
    input  logic               vlan_tagged,
    output logic [ETYPE_W-1:0] ethertype,
    output logic [VID_W-1:0]   vlan_id1,
    output logic [VID_W-1:0]   vlan_id2,
    output logic [SID_W-1:0]   session_id,
    output logic               pppoe_on
);

    localparam logic [ETYPE_W-1:0] STACK_MASK = ETYPE_W'(1) << STACK_BIT;

    l2tag_op_e          op;
    logic [ETYPE_W-1:0] et_q, et_d, port_hot;
    logic [VID_W-1:0]   v1_q, v1_d, v2_q, v2_d;
    logic [SID_W-1:0]   sid_q, sid_d;
    logic               ppp_q, ppp_d;
    logic               no_layers;
    logic               is_v6;

    assign op        = l2tag_op_e'(cmd_op);
    assign no_layers = (layer_cnt == LAYER_W'(0));
    assign is_v6     = (cmd_arg[TYPE_W-1:0] >= TYPE_W'(V6_MIN));
    assign port_hot  = ETYPE_W'(1) << cmd_arg[PORT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            et_q  <= '0;
            v1_q  <= '0;
            v2_q  <= '0;
            sid_q <= '0;
            ppp_q <= 1'b0;
        end else begin
            et_q  <= et_d;
            v1_q  <= v1_d;
            v2_q  <= v2_d;
            sid_q <= sid_d;
            ppp_q <= ppp_d;
        end
    end

    always_comb begin
        et_d  = et_q;
        v1_d  = v1_q;
        v2_d  = v2_q;
        sid_d = sid_q;
        ppp_d = ppp_q;
        if (cmd_valid) begin
            unique case (op)
                OP_INIT: begin
                    et_d  = is_v6 ? ETYPE_W'(ETYPE_IPV6) : ETYPE_W'(ETYPE_IPV4);
                    v1_d  = '0;
                    v2_d  = '0;
                    sid_d = '0;
                    ppp_d = 1'b0;
                end
                OP_VLAN: begin
                    if (no_layers) begin
                        v1_d = cmd_arg[VID_W-1:0];
                    end else if (layer_cnt == LAYER_W'(1)) begin
                        if (vlan_tagged) begin
                            v2_d = cmd_arg[VID_W-1:0];
                        end else begin
                            v1_d = cmd_arg[VID_W-1:0];
                            et_d = et_q | STACK_MASK;
                        end
                    end
                end
                OP_PORT: begin
                    et_d = no_layers ? port_hot : (port_hot | STACK_MASK);
                end
                OP_PPPOE: begin
                    if (no_layers || vlan_tagged)
                        et_d = ETYPE_W'(ETYPE_PPP_SESS);
                    ppp_d = 1'b1;
                    sid_d = cmd_arg[SID_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign ethertype  = et_q;
    assign vlan_id1   = v1_q;
    assign vlan_id2   = v2_q;
    assign session_id = sid_q;
    assign pppoe_on   = ppp_q;

endmodule

// File: rtl/l2tag_builder.sv
module l2tag_builder
    import l2tag_pkg::*;
#(
    parameter int ARG_W   = 16,
    parameter int ETYPE_W = 16,
    parameter int VID_W   = 12,
    parameter int PORT_W  = 3,
    parameter int SID_W   = 16,
    parameter int TYPE_W  = 3,
    parameter int V6_MIN  = 4,
    parameter int LAYER_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [ARG_W-1:0]   cmd_arg,
    output logic [LAYER_W-1:0] layer_cnt,
    output logic               vlan_tagged,
    output logic               pppoe_on,
    output logic [ETYPE_W-1:0] ethertype,
    output logic [VID_W-1:0]   vlan_id1,
    output logic [VID_W-1:0]   vlan_id2,
    output logic [SID_W-1:0]   session_id,
    output logic               err_nospace
);

    l2tag_fsm #(.LAYER_W(LAYER_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .layer_cnt   (layer_cnt),
        .vlan_tagged (vlan_tagged),
        .err_nospace (err_nospace)
    );

    l2tag_fields #(
        .ARG_W   (ARG_W),
        .ETYPE_W (ETYPE_W),
        .VID_W   (VID_W),
        .PORT_W  (PORT_W),
        .SID_W   (SID_W),
        .TYPE_W  (TYPE_W),
        .V6_MIN  (V6_MIN),
        .LAYER_W (LAYER_W)
    ) u_fields (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_arg     (cmd_arg),
        .layer_cnt   (layer_cnt),
        .vlan_tagged (vlan_tagged),
        .ethertype   (ethertype),
        .vlan_id1    (vlan_id1),
        .vlan_id2    (vlan_id2),
        .session_id  (session_id),
        .pppoe_on    (pppoe_on)
    );

endmodule

// File: rtl/l2tag_chk.sv
module l2tag_chk #(
    parameter int ETYPE_W = 16,
    parameter int VID_W   = 12,
    parameter int SID_W   = 16,
    parameter int LAYER_W = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic [LAYER_W-1:0] layer_cnt,
    input logic               vlan_tagged,
    input logic               pppoe_on,
    input logic [ETYPE_W-1:0] ethertype,
    input logic [VID_W-1:0]   vlan_id1,
    input logic [VID_W-1:0]   vlan_id2,
    input logic [SID_W-1:0]   session_id,
    input logic               err_nospace
);

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        layer_cnt <= LAYER_W'(2));

    // R11
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err_nospace |-> ($past(cmd_valid) && $past(cmd_op) == 2'd1 && $past(layer_cnt) == LAYER_W'(2)));

    // R8
    full_push_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1 && layer_cnt == LAYER_W'(2)) |=>
        (err_nospace && $stable(layer_cnt) && $stable(vlan_tagged) && $stable(ethertype)
         && $stable(vlan_id1) && $stable(vlan_id2)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!err_nospace && $stable(layer_cnt) && $stable(vlan_tagged)
         && $stable(pppoe_on) && $stable(ethertype) && $stable(vlan_id1)
         && $stable(vlan_id2) && $stable(session_id)));

    // R3
    port_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd2) |=>
        ($countones(ethertype[7:0]) == 1 && !vlan_tagged && layer_cnt != LAYER_W'(0)));

    // R9
    pppoe_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd3) |=> pppoe_on);

endmodule

bind l2tag_builder l2tag_chk #(
    .ETYPE_W (ETYPE_W),
    .VID_W   (VID_W),
    .SID_W   (SID_W),
    .LAYER_W (LAYER_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .layer_cnt   (layer_cnt),
    .vlan_tagged (vlan_tagged),
    .pppoe_on    (pppoe_on),
    .ethertype   (ethertype),
    .vlan_id1    (vlan_id1),
    .vlan_id2    (vlan_id2),
    .session_id  (session_id),
    .err_nospace (err_nospace)
);

// File: tb/l2tag_builder_tb.sv
`timescale 1ns/1ps
module l2tag_builder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_arg = 16'd0;
    logic [2:0]  layer_cnt;
    logic        vlan_tagged, pppoe_on, err_nospace;
    logic [15:0] ethertype, session_id;
    logic [11:0] vlan_id1, vlan_id2;

    always #4 clk = ~clk;

    l2tag_builder u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .layer_cnt(layer_cnt), .vlan_tagged(vlan_tagged), .pppoe_on(pppoe_on),
        .ethertype(ethertype), .vlan_id1(vlan_id1), .vlan_id2(vlan_id2),
        .session_id(session_id), .err_nospace(err_nospace)
    );

    typedef struct {
        string       tag;
        logic [2:0]  layers;
        logic        tagf;
        logic        ppp;
        logic [15:0] et;
        logic [11:0] v1;
        logic [11:0] v2;
        logic [15:0] sid;
        logic        err;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_item;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [2:0]  m_layers = 0;
    logic        m_tag = 0, m_ppp = 0;
    logic [15:0] m_et = 0, m_sid = 0;
    logic [11:0] m_v1 = 0, m_v2 = 0;

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // driver: apply one command and push the expected result
    task automatic send(input bit valid, input logic [1:0] op, input logic [15:0] arg, input string tag);
        exp_t it;
        logic err_e;
        logic [15:0] hot;
        @(negedge clk);
        cmd_valid = valid;
        cmd_op    = op;
        cmd_arg   = arg;
        err_e     = 1'b0;
        if (valid) begin
            case (op)
                2'd0: begin
                    m_layers = 0; m_tag = 0; m_ppp = 0; m_v1 = 0; m_v2 = 0; m_sid = 0;
                    m_et = (arg[2:0] >= 3'd4) ? 16'h86DD : 16'h0800;
                end
                2'd1: begin
                    if (m_layers == 0) begin
                        m_v1 = arg[11:0]; m_tag = 1; m_layers = 1;
                    end else if (m_layers == 1) begin
                        if (!m_tag) begin m_v1 = arg[11:0]; m_et = m_et | 16'h0100; end
                        else begin m_v2 = arg[11:0]; m_layers = 2; end
                    end else err_e = 1'b1;
                end
                2'd2: begin
                    hot = 16'h0001 << arg[2:0];
                    if (m_layers == 0) m_layers = 1;
                    else hot = hot | 16'h0100;
                    m_et = hot; m_tag = 0;
                end
                default: begin
                    if (m_layers == 0 || m_tag) m_et = 16'h8864;
                    m_ppp = 1; m_sid = arg;
                end
            endcase
        end
        it.tag = tag; it.layers = m_layers; it.tagf = m_tag; it.ppp = m_ppp;
        it.et = m_et; it.v1 = m_v1; it.v2 = m_v2; it.sid = m_sid; it.err = err_e;
        exp_q.push_back(it);
    endtask

    // monitor: compare after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            mon_item = exp_q.pop_front();
            chk(mon_item.tag, "layer_cnt",   16'(layer_cnt),   16'(mon_item.layers));
            chk(mon_item.tag, "vlan_tagged", 16'(vlan_tagged), 16'(mon_item.tagf));
            chk(mon_item.tag, "pppoe_on",    16'(pppoe_on),    16'(mon_item.ppp));
            chk(mon_item.tag, "ethertype",   ethertype,        mon_item.et);
            chk(mon_item.tag, "vlan_id1",    16'(vlan_id1),    16'(mon_item.v1));
            chk(mon_item.tag, "vlan_id2",    16'(vlan_id2),    16'(mon_item.v2));
            chk(mon_item.tag, "session_id",  session_id,       mon_item.sid);
            chk(mon_item.tag, "err_nospace", 16'(err_nospace), 16'(mon_item.err));
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "layer_cnt", 16'(layer_cnt), 16'd0);
        chk("R1", "flags", {14'd0, vlan_tagged, pppoe_on}, 16'd0);
        chk("R1", "ethertype", ethertype, 16'd0);
        chk("R1", "vlans", {4'd0, vlan_id1 | vlan_id2}, 16'd0);
        chk("R1", "session_id", session_id, 16'd0);
        chk("R1", "err_nospace", 16'(err_nospace), 16'd0);

        send(1, 2'd0, 16'h0000, "R2 init v4");
        send(1, 2'd0, 16'h0004, "R2 init v6 lowest");
        send(1, 2'd0, 16'h0007, "R2 init v6 highest");
        send(1, 2'd0, 16'h0003, "R2 init v4 highest");
        send(1, 2'd1, 16'h0123, "R5 vlan at zero");
        send(1, 2'd1, 16'h0456, "R7 vlan into slot 2");
        send(1, 2'd1, 16'h0789, "R8 overflow");
        send(1, 2'd1, 16'h0abc, "R8 overflow again");
        send(1, 2'd3, 16'h1234, "R9 pppoe with tag");
        send(1, 2'd2, 16'h0003, "R4 port at two layers");
        send(1, 2'd1, 16'h0111, "R8 overflow after port");
        send(1, 2'd3, 16'h0055, "R9 pppoe keeps ethertype");
        send(1, 2'd0, 16'h0000, "R2 init clears");
        send(1, 2'd2, 16'h0005, "R3 port at zero");
        send(1, 2'd1, 16'h00ab, "R6 vlan over port");
        send(1, 2'd1, 16'h00cd, "R6 vlan over port again");
        send(1, 2'd2, 16'h0000, "R4 port at one layer");
        send(0, 2'd1, 16'hffff, "R10 idle vlan");
        send(0, 2'd0, 16'h0004, "R10 idle init");
        send(1, 2'd0, 16'h0005, "R2 init v6");
        send(1, 2'd3, 16'hbeef, "R9 pppoe at zero");
        send(1, 2'd0, 16'h0001, "R2 init v4 again");
        send(1, 2'd1, 16'h0010, "R5 vlan");
        send(1, 2'd2, 16'h0007, "R4 port over vlan");
        send(1, 2'd3, 16'h0042, "R9 pppoe after port");
        send(1, 2'd1, 16'h0020, "R6 vlan after port");
        send(0, 2'd3, 16'h0000, "R10 R11 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end

endmodule